// File: doc/BRIEF.md
# Relative Branch and Subroutine Unit

This unit executes the control-flow opcodes (low nibble 0 to F, upper nibble zero) of a small 16-bit register machine whose sixteen registers live outside the unit. The execution core hands it a four-bit opcode, the displacement byte and the address of the opcode with a one-cycle start strobe. The unit replies with a one-cycle done pulse and the next program address. It also gives an exit pulse for the opcode that leaves the interpreter and a break pulse for the opcode that traps to a debugger.

There are no stored sign or zero flags. The unit keeps only a four-bit prior-result register number and a carry bit, and the core loads both through strobes. A conditional branch reads the indicated register through the register-file read port and judges it as it stands. Subroutine call and return keep their return addresses in byte memory, addressed by register 12, which acts as a stack pointer that grows upwards. The unit reaches that memory through a synchronous-read byte port and updates register 12 through the register-file write port.

Top module: `rbr_unit`

## Requirements
- R1: After reset, done_o, exit_o, brk_o, rf_we_o, mem_we_o and mem_re_o are low, carry_o is 0 and prior_idx_o is 0.
- R2: For opcodes 1 to 9, done_o pulses two cycles after the start cycle. next_pc_o is the target pc_i + 2 + sign-extended disp_i (modulo 2^16) when the branch is taken, and pc_i + 2 when it is not.
- R3: Opcode 1 always branches, opcode 2 branches when carry is 0, and opcode 3 branches when carry is 1.
- R4: The register named by the prior-result index is read. Opcode 4 branches when its bit 15 is 0 and opcode 5 when bit 15 is 1. Opcode 6 branches when all 16 bits are zero and opcode 7 when any bit is set.
- R5: Opcode 8 branches when the indicated register equals FFFF, and opcode 9 when it does not.
- R6: Opcodes 0 to 9 and 10, 13, 14 and 15 leave carry_o and prior_idx_o unchanged. They make no register-file write and no memory write.
- R7: Opcodes 0, 10, 13, 14 and 15 set next_pc_o to pc_i + 1 with done_o. Opcode 0 also pulses exit_o and opcode 10 also pulses brk_o in that cycle. Opcodes 13 to 15 pulse neither.
- R8: Opcode 12 (call) first writes the low byte of pc_i + 2 to memory address R12, then writes the high byte to R12 + 1. It then writes R12 + 2 back into register 12 and sets next_pc_o to the relative target. It clears carry and sets the prior-result index to 0.
- R9: Opcode 11 (return) reads the high byte from R12 - 1 and then the low byte from R12 - 2. It writes R12 - 2 back into register 12 and sets next_pc_o to the address read.
- R10: st_res_we_i loads prior_idx_o from st_res_idx_i and st_c_we_i loads carry_o from st_c_i. A strobe given in the same cycle as start_i is seen by the condition of that branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin one control-flow opcode (accepted when idle) |
| op_i | input | 4 | Opcode low nibble |
| disp_i | input | 8 | Signed displacement byte |
| pc_i | input | 16 | Address of the opcode |
| st_res_we_i | input | 1 | Load the prior-result index |
| st_res_idx_i | input | 4 | New prior-result register number |
| st_c_we_i | input | 1 | Load the carry bit |
| st_c_i | input | 1 | New carry value |
| rf_raddr_o | output | 4 | Register-file read address |
| rf_rdata_i | input | 16 | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_waddr_o | output | 4 | Register-file write address |
| rf_wdata_o | output | 16 | Register-file write data |
| mem_addr_o | output | 16 | Byte memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_re_o | output | 1 | Memory read strobe (data on the following cycle) |
| mem_rdata_i | input | 8 | Memory read data |
| done_o | output | 1 | Opcode complete; next_pc_o valid |
| next_pc_o | output | 16 | Address of the next opcode |
| exit_o | output | 1 | Leave the interpreter |
| brk_o | output | 1 | Break trap |
| carry_o | output | 1 | Stored carry |
| prior_idx_o | output | 4 | Stored prior-result register number |

## Verification
The two functions that can meet in one cycle are a status strobe from the core and the start of a conditional branch. In one test, carry and the prior-result index are first set so that a branch would fall through. The same branch is then started together with a strobe that changes them. The check is that next_pc_o follows the new value. Around this, a sweep covers every condition opcode against edge register values, both carry states and extreme displacements, with the outcome computed arithmetically. Nested calls and returns are checked against the bytes and stack pointer held in the bench's memory and register models.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

  typedef enum logic [3:0] {
    OP_EXIT  = 4'h0,
    OP_JMP   = 4'h1,
    OP_JNC   = 4'h2,
    OP_JC    = 4'h3,
    OP_JPL   = 4'h4,
    OP_JMI   = 4'h5,
    OP_JZ    = 4'h6,
    OP_JNZ   = 4'h7,
    OP_JM1   = 4'h8,
    OP_JNM1  = 4'h9,
    OP_BREAK = 4'hA,
    OP_RET   = 4'hB,
    OP_CALL  = 4'hC,
    OP_NOPD  = 4'hD,
    OP_NOPE  = 4'hE,
    OP_NOPF  = 4'hF
  } rop_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EVAL,
    S_PUSH,
    S_CFIN,
    S_POPA,
    S_POPB,
    S_POPC
  } rstate_e;

  function automatic logic is_cond(input logic [3:0] op);
    return (op >= 4'h1) && (op <= 4'h9);
  endfunction

endpackage

// File: rtl/rbr_status.sv
module rbr_status #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_we,
  input  logic [IDX_W-1:0] res_idx,
  input  logic             c_we,
  input  logic             c_in,
  input  logic             clr,
  output logic [IDX_W-1:0] idx_o,
  output logic             c_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_o <= '0;
      c_o   <= 1'b0;
    end else if (clr) begin
      idx_o <= '0;
      c_o   <= 1'b0;
    end else begin
      if (res_we) idx_o <= res_idx;
      if (c_we)   c_o   <= c_in;
    end
  end

  // R8: a call completion leaves carry clear and index 0
  p_call_clears_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!c_o && idx_o == '0));

  // R10: strobe loads the index
  p_idx_load_r10: assert property (@(posedge clk) disable iff (rst)
    (res_we && !clr) |=> (idx_o == $past(res_idx)));

  // R6: without a strobe or clear the index holds
  p_idx_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!res_we && !clr) |=> $stable(idx_o));

  // R6: without a strobe or clear the carry holds
  p_c_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!c_we && !clr) |=> $stable(c_o));

endmodule

// File: rtl/rbr_cond.sv
module rbr_cond #(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic         carry,
  input  logic [W-1:0] val,
  output logic         take
);
  import rbr_pkg::*;

  logic neg, zero, ones;

  assign neg  = val[W-1];
  assign zero = ~|val;
  assign ones = &val;

  always_comb begin
    case (op)
      OP_JMP:  take = 1'b1;
      OP_JNC:  take = ~carry;
      OP_JC:   take = carry;
      OP_JPL:  take = ~neg;
      OP_JMI:  take = neg;
      OP_JZ:   take = zero;
      OP_JNZ:  take = ~zero;
      OP_JM1:  take = ones;
      OP_JNM1: take = ~ones;
      default: take = 1'b0;
    endcase
  end

endmodule

// File: rtl/rbr_target.sv
module rbr_target #(
  parameter int W = 16
) (
  input  logic [W-1:0] pc,
  input  logic [7:0]   disp,
  output logic [W-1:0] seq,
  output logic [W-1:0] tgt
);

  localparam int INSN_LEN = 2;

  logic [W-1:0] dext;

  assign dext = {{(W-8){disp[7]}}, disp};
  assign seq  = pc + W'(INSN_LEN);
  assign tgt  = seq + dext;

endmodule

// File: rtl/rbr_unit.sv
module rbr_unit #(
  parameter int W      = 16,
  parameter int NREG   = 16,
  parameter int SP_REG = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [3:0]              op_i,
  input  logic [7:0]              disp_i,
  input  logic [W-1:0]            pc_i,
  input  logic                    st_res_we_i,
  input  logic [$clog2(NREG)-1:0] st_res_idx_i,
  input  logic                    st_c_we_i,
  input  logic                    st_c_i,
  output logic [$clog2(NREG)-1:0] rf_raddr_o,
  input  logic [W-1:0]            rf_rdata_i,
  output logic                    rf_we_o,
  output logic [$clog2(NREG)-1:0] rf_waddr_o,
  output logic [W-1:0]            rf_wdata_o,
  output logic [W-1:0]            mem_addr_o,
  output logic                    mem_we_o,
  output logic [7:0]              mem_wdata_o,
  output logic                    mem_re_o,
  input  logic [7:0]              mem_rdata_i,
  output logic                    done_o,
  output logic [W-1:0]            next_pc_o,
  output logic                    exit_o,
  output logic                    brk_o,
  output logic                    carry_o,
  output logic [$clog2(NREG)-1:0] prior_idx_o
);
  import rbr_pkg::*;

  localparam int IDX_W = $clog2(NREG);
  localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(SP_REG);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  rstate_e      state;
  logic [3:0]   op_q;
  logic [7:0]   disp_q;
  logic [W-1:0] pc_q;
  logic [W-1:0] sp_q;
  logic [W-9:0] hi_q;
  logic [W-1:0] seq, tgt;
  logic         take;
  logic         stack_op;

  assign stack_op   = (op_q == OP_CALL) || (op_q == OP_RET);
  assign rf_raddr_o = stack_op ? SP_IDX : prior_idx_o;

  rbr_status #(.IDX_W(IDX_W)) u_status (
    .clk     (clk),
    .rst     (rst),
    .res_we  (st_res_we_i),
    .res_idx (st_res_idx_i),
    .c_we    (st_c_we_i),
    .c_in    (st_c_i),
    .clr     (state == S_CFIN),
    .idx_o   (prior_idx_o),
    .c_o     (carry_o)
  );

  rbr_cond #(.W(W)) u_cond (
    .op    (op_q),
    .carry (carry_o),
    .val   (rf_rdata_i),
    .take  (take)
  );

  rbr_target #(.W(W)) u_target (
    .pc   (pc_q),
    .disp (disp_q),
    .seq  (seq),
    .tgt  (tgt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      op_q        <= '0;
      disp_q      <= '0;
      pc_q        <= '0;
      sp_q        <= '0;
      hi_q        <= '0;
      rf_we_o     <= 1'b0;
      rf_waddr_o  <= '0;
      rf_wdata_o  <= '0;
      mem_addr_o  <= '0;
      mem_we_o    <= 1'b0;
      mem_wdata_o <= '0;
      mem_re_o    <= 1'b0;
      done_o      <= 1'b0;
      next_pc_o   <= '0;
      exit_o      <= 1'b0;
      brk_o       <= 1'b0;
    end else begin
      done_o   <= 1'b0;
      exit_o   <= 1'b0;
      brk_o    <= 1'b0;
      rf_we_o  <= 1'b0;
      mem_we_o <= 1'b0;
      mem_re_o <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_i) begin
            op_q   <= op_i;
            disp_q <= disp_i;
            pc_q   <= pc_i;
            state  <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (op_q == OP_CALL) begin
            sp_q        <= rf_rdata_i;
            mem_we_o    <= 1'b1;
            mem_addr_o  <= rf_rdata_i;
            mem_wdata_o <= seq[7:0];
            state       <= S_PUSH;
          end else if (op_q == OP_RET) begin
            sp_q       <= rf_rdata_i;
            mem_re_o   <= 1'b1;
            mem_addr_o <= rf_rdata_i - ONE;
            state      <= S_POPA;
          end else begin
            done_o <= 1'b1;
            if (is_cond(op_q)) next_pc_o <= take ? tgt : seq;
            else               next_pc_o <= pc_q + ONE;
            exit_o <= (op_q == OP_EXIT);
            brk_o  <= (op_q == OP_BREAK);
            state  <= S_IDLE;
          end
        end
        S_PUSH: begin
          mem_we_o    <= 1'b1;
          mem_addr_o  <= sp_q + ONE;
          mem_wdata_o <= 8'(seq >> 8);
          state       <= S_CFIN;
        end
        S_CFIN: begin
          rf_we_o    <= 1'b1;
          rf_waddr_o <= SP_IDX;
          rf_wdata_o <= sp_q + TWO;
          next_pc_o  <= tgt;
          done_o     <= 1'b1;
          state      <= S_IDLE;
        end
        S_POPA: begin
          mem_re_o   <= 1'b1;
          mem_addr_o <= sp_q - TWO;
          state      <= S_POPB;
        end
        S_POPB: begin
          hi_q  <= mem_rdata_i[W-9:0];
          state <= S_POPC;
        end
        S_POPC: begin
          rf_we_o    <= 1'b1;
          rf_waddr_o <= SP_IDX;
          rf_wdata_o <= sp_q - TWO;
          next_pc_o  <= {hi_q, mem_rdata_i};
          done_o     <= 1'b1;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: exit and break only appear with done, never both
  p_exit_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    (exit_o || brk_o) |-> (done_o && !(exit_o && brk_o)));

  // R8: the second push byte goes one address above the first
  p_push_rising_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + ONE));

  // R9: the second pop read is one address below the first
  p_pop_falling_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_re_o && $past(mem_re_o)) |-> (mem_addr_o == $past(mem_addr_o) - ONE));

  // R6: register writes only target the stack pointer, at completion
  p_rf_only_sp_r6: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> (done_o && rf_waddr_o == SP_IDX));

  // R2: a conditional branch ends at fall-through or target
  p_branch_dest_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_EVAL && is_cond(op_q)) |=>
      (done_o && (next_pc_o == $past(seq) || next_pc_o == $past(tgt))));

  // R6: no memory traffic for non-stack opcodes
  p_no_mem_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_EVAL && !stack_op) |=> (!mem_we_o && !mem_re_o));

endmodule

// File: tb/sim_rbr_unit.sv
`timescale 1ns/1ps
module sim_rbr_unit;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, start_i, st_res_we_i, st_c_we_i, st_c_i;
  logic [3:0] op_i, st_res_idx_i, rf_raddr_o, rf_waddr_o, prior_idx_o;
  logic [7:0] disp_i, mem_wdata_o, mem_rdata_i;
  logic [W-1:0] pc_i, rf_rdata_i, rf_wdata_o, mem_addr_o, next_pc_o;
  logic rf_we_o, mem_we_o, mem_re_o, done_o, exit_o, brk_o, carry_o;

  rbr_unit u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .disp_i(disp_i),
    .pc_i(pc_i), .st_res_we_i(st_res_we_i), .st_res_idx_i(st_res_idx_i),
    .st_c_we_i(st_c_we_i), .st_c_i(st_c_i), .rf_raddr_o(rf_raddr_o),
    .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
    .rf_wdata_o(rf_wdata_o), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
    .mem_wdata_o(mem_wdata_o), .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .next_pc_o(next_pc_o), .exit_o(exit_o), .brk_o(brk_o),
    .carry_o(carry_o), .prior_idx_o(prior_idx_o)
  );

  // register file and byte memory models
  logic [W-1:0] rf [16];
  logic tb_rwe;
  logic [3:0] tb_ra;
  logic [W-1:0] tb_rd;
  always @(posedge clk) begin
    if (rf_we_o) rf[rf_waddr_o] <= rf_wdata_o;
    else if (tb_rwe) rf[tb_ra] <= tb_rd;
  end
  assign rf_rdata_i = rf[rf_raddr_o];

  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
    if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[7:0]];
  end

  int wr_cnt;
  logic cnt_clr;
  always @(posedge clk) begin
    if (cnt_clr) wr_cnt <= 0;
    else if (rf_we_o || mem_we_o) wr_cnt <= wr_cnt + 1;
  end

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] got_pc;
  logic got_exit, got_brk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_reg(input logic [3:0] a, input logic [W-1:0] v);
    @(negedge clk); tb_rwe = 1'b1; tb_ra = a; tb_rd = v;
    @(negedge clk); tb_rwe = 1'b0;
  endtask

  task automatic strobe(input logic [3:0] idx, input logic c);
    @(negedge clk);
    st_res_we_i = 1'b1; st_res_idx_i = idx; st_c_we_i = 1'b1; st_c_i = c;
    @(negedge clk);
    st_res_we_i = 1'b0; st_c_we_i = 1'b0;
  endtask

  task automatic run(input logic [3:0] op, input logic [7:0] d, input logic [W-1:0] pc,
                     input logic rw, input logic [3:0] ri, input logic cw, input logic cv);
    @(negedge clk);
    start_i = 1'b1; op_i = op; disp_i = d; pc_i = pc; cnt_clr = 1'b1;
    st_res_we_i = rw; st_res_idx_i = ri; st_c_we_i = cw; st_c_i = cv;
    @(negedge clk);
    start_i = 1'b0; cnt_clr = 1'b0; st_res_we_i = 1'b0; st_c_we_i = 1'b0;
    for (int k = 0; k < 20 && !done_o; k++) @(negedge clk);
    chk("R2 done seen", {31'd0, done_o}, 32'd1);
    got_pc = next_pc_o; got_exit = exit_o; got_brk = brk_o;
  endtask

  function automatic logic exp_take(input int op, input logic [15:0] v, input logic c);
    case (op)
      1: return 1'b1;
      2: return !c;
      3: return c;
      4: return !v[15];
      5: return v[15];
      6: return v == 16'h0000;
      7: return v != 16'h0000;
      8: return v == 16'hFFFF;
      default: return v != 16'hFFFF;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] vals [6];
    logic [7:0]  disps [5];
    logic [15:0] pc, exp_pc;
    vals  = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
    disps = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h05};
    rst = 1'b1; start_i = 0; op_i = 0; disp_i = 0; pc_i = 0;
    st_res_we_i = 0; st_res_idx_i = 0; st_c_we_i = 0; st_c_i = 0;
    tb_rwe = 0; tb_ra = 0; tb_rd = 0; cnt_clr = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs idle", {26'd0, done_o, exit_o, brk_o, rf_we_o, mem_we_o, mem_re_o}, 32'd0);
    chk("R1 carry", {31'd0, carry_o}, 32'd0);
    chk("R1 prior index", {28'd0, prior_idx_o}, 32'd0);

    // R3 R4 R5 R6 condition sweep
    for (int op = 1; op <= 9; op++)
      for (int vi = 0; vi < 6; vi++)
        for (int c = 0; c < 2; c++)
          for (int di = 0; di < 5; di++) begin
            set_reg(4'(vi + 1), vals[vi]);
            strobe(4'(vi + 1), c[0]);
            pc = 16'h3000 + 16'(op * 256 + di * 16 + vi);
            run(4'(op), disps[di], pc, 0, 0, 0, 0);
            exp_pc = exp_take(op, vals[vi], c[0]) ? pc + 16'd2 + {{8{disps[di][7]}}, disps[di]}
                                                  : pc + 16'd2;
            chk(op <= 3 ? "R3 branch next pc" : (op <= 7 ? "R4 branch next pc" : "R5 branch next pc"),
                {16'd0, got_pc}, {16'd0, exp_pc});
            chk("R6 carry kept", {31'd0, carry_o}, {31'd0, c[0]});
            chk("R6 index kept", {28'd0, prior_idx_o}, 32'(vi + 1));
            chk("R6 no writes", 32'(wr_cnt), 32'd0);
          end

    // R2 wrap-around of target
    run(4'h1, 8'h01, 16'hFFFF, 0, 0, 0, 0);
    chk("R2 forward wrap", {16'd0, got_pc}, 32'h0002);
    run(4'h1, 8'h80, 16'h0001, 0, 0, 0, 0);
    chk("R2 backward wrap", {16'd0, got_pc}, 32'hFF83);

    // R7 one-byte opcodes
    foreach (vals[i]) begin
      for (int k = 0; k < 5; k++) begin
        logic [3:0] o;
        o = (k == 0) ? 4'h0 : (k == 1) ? 4'hA : 4'(12 + k - 1);
        strobe(4'h3, 1'b1);
        run(o, 8'h55, vals[i], 0, 0, 0, 0);
        chk("R7 next pc plus one", {16'd0, got_pc}, {16'd0, vals[i] + 16'd1});
        chk("R7 exit pulse", {31'd0, got_exit}, {31'd0, o == 4'h0});
        chk("R7 break pulse", {31'd0, got_brk}, {31'd0, o == 4'hA});
        chk("R6 one-byte no writes", 32'(wr_cnt), 32'd0);
        chk("R6 one-byte carry kept", {31'd0, carry_o}, 32'd1);
      end
    end

    // R10 strobe in the start cycle steers the branch
    strobe(4'h1, 1'b0);
    run(4'h3, 8'h10, 16'h5000, 0, 0, 1, 1);
    chk("R10 carry strobe with start", {16'd0, got_pc}, 32'h5012);
    set_reg(4'h1, 16'h00FF);
    set_reg(4'h2, 16'h0000);
    run(4'h6, 8'hF0, 16'h6000, 1, 4'h2, 0, 0);
    chk("R10 index strobe with start", {16'd0, got_pc}, 32'h5FF2);
    chk("R10 index loaded", {28'd0, prior_idx_o}, 32'd2);

    // R8 nested calls
    set_reg(4'd12, 16'h0040);
    strobe(4'h5, 1'b1);
    run(4'hC, 8'h10, 16'h1234, 0, 0, 0, 0);
    chk("R8 call target", {16'd0, got_pc}, 32'h1246);
    @(negedge clk);
    chk("R8 low byte first", {24'd0, mem[8'h40]}, 32'h36);
    chk("R8 high byte next", {24'd0, mem[8'h41]}, 32'h12);
    chk("R8 stack pointer up", {16'd0, rf[12]}, 32'h0042);
    chk("R8 carry cleared", {31'd0, carry_o}, 32'd0);
    chk("R8 index zero", {28'd0, prior_idx_o}, 32'd0);
    run(4'hC, 8'hF0, 16'h2000, 0, 0, 0, 0);
    chk("R8 second call target", {16'd0, got_pc}, 32'h1FF2);
    @(negedge clk);
    chk("R8 second push", {16'd0, mem[8'h43], mem[8'h42]}, 32'h2002);
    chk("R8 stack pointer again", {16'd0, rf[12]}, 32'h0044);

    // R9 returns unwind in order
    run(4'hB, 8'h00, 16'h7777, 0, 0, 0, 0);
    chk("R9 inner return", {16'd0, got_pc}, 32'h2002);
    @(negedge clk);
    chk("R9 stack pointer down", {16'd0, rf[12]}, 32'h0042);
    run(4'hB, 8'h00, 16'h8888, 0, 0, 0, 0);
    chk("R9 outer return", {16'd0, got_pc}, 32'h1236);
    @(negedge clk);
    chk("R9 stack pointer restored", {16'd0, rf[12]}, 32'h0040);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule